// File: doc/BRIEF.md
# Exception Cause Register Unit

This unit sits beside the execute and memory stages of a small 32-bit core and turns raw hardware fault events into one recorded cause. Six kinds of event can ask for a trap: a divide whose divisor is zero, a data access that is not naturally aligned, a stack access outside the configured window, a bus error on an instruction fetch, a bus error on a data load or store, and a floating-point operation that raised a flag. Each request is qualified by the global exception-enable bit and by its own configuration enable. The stack check is the exception: it is always active.

When at least one qualified request is present in a cycle, the unit picks the most urgent one. On the next clock edge it writes that request's cause code into the exception status register and raises a one-cycle take pulse for the pipeline. For a misaligned access the register also records the access direction and the destination register index. The unit also forces the quotient to zero when the divisor is zero, so that a divide that is not trapped still completes with a defined result.

Top module: `exc_cause_unit`

## Requirements
- R1: While reset is low at a clock edge, `esr` becomes 0 and `exc_take` becomes 0 after that edge.
- R2: A divide request with `div_divisor` equal to 0 records cause 0x05 in `esr[4:0]` only when `irq_en`, `cfg_divz_en` and no higher request are present. A nonzero divisor never traps.
- R3: `div_quot_out` is 0 whenever `div_divisor` is 0, whether or not the divide traps. Otherwise it equals `div_quot_in`, in the same cycle.
- R4: A misaligned access with `irq_en` set records cause 0x01 in `esr[4:0]`, `mis_wr` in bit 10 and `mis_rd` in bits 9:5, with every other bit 0. With `irq_en` clear it records nothing and raises no pulse.
- R5: A stack access traps with cause 0x07 when `stk_addr` is strictly below `stk_lo` or strictly above `stk_hi` (unsigned). An address equal to either limit is legal. This check does not depend on `irq_en`.
- R6: An instruction-bus error records cause 0x03 only when both `irq_en` and `cfg_ibus_en` are set.
- R7: A data-bus error records cause 0x04 only when both `irq_en` and `cfg_dbus_en` are set.
- R8: A floating-point request records cause 0x06 only when `fpu_flags` is nonzero and both `cfg_fpu_en` and `irq_en` are set.
- R9: When several qualified requests arrive in one cycle, the winner is chosen in this order: instruction bus, data bus, misaligned, stack, divide, FPU. Only the winner's value is written to `esr`. A disabled request never blocks a lower one.
- R10: `exc_take` is high for exactly the cycle after a cycle with a qualified request. `esr` keeps its value in every cycle with no take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_en | input | 1 | Global exception enable from the machine status |
| cfg_ibus_en | input | 1 | Configuration: trap on instruction-bus error |
| cfg_dbus_en | input | 1 | Configuration: trap on data-bus error |
| cfg_divz_en | input | 1 | Configuration: trap on zero divisor |
| cfg_fpu_en | input | 1 | Configuration: trap on floating-point flags |
| ibus_err | input | 1 | Instruction fetch bus error strobe |
| dbus_err | input | 1 | Data load/store bus error strobe |
| mis_req | input | 1 | Misaligned data access strobe |
| mis_wr | input | 1 | Misaligned access is a store (1) or load (0) |
| mis_rd | input | 5 | Destination register index of the misaligned access |
| stk_req | input | 1 | Stack-relative access strobe |
| stk_addr | input | 32 | Address of the stack access |
| stk_lo | input | 32 | Lowest legal stack address |
| stk_hi | input | 32 | Highest legal stack address |
| div_req | input | 1 | Divide issue strobe |
| div_divisor | input | 32 | Divisor operand |
| div_quot_in | input | 32 | Quotient from the divider datapath |
| div_quot_out | output | 32 | Quotient after zero-divisor override |
| fpu_req | input | 1 | Floating-point result strobe |
| fpu_flags | input | 4 | Exception flags of that result |
| esr | output | 32 | Exception status register |
| exc_take | output | 1 | One-cycle pulse: an exception was accepted |

## Verification
A vector table first drives each source alone. It tries every combination of global enable and configuration bit that separates a gated trap from an ignored one. For the stack check it drives addresses one below, equal to and one above each limit, which separates strict bounds from inclusive ones. Mixed vectors then remove the highest request one at a time, which shows the whole priority order and that only the winner's payload lands in the register. Further checks cover a disabled high-priority source that must let a lower one win, the quotient override with zero and nonzero divisors, and reset in the middle of a run.

// File: rtl/exc_pkg.sv
// Shared constants for the exception cause unit.
// Assumes a cause field of five bits at the bottom of the status word.
package exc_pkg;
    localparam int CAUSE_W = 5;
    localparam int NSRC    = 6;

    // Source indices in falling priority (index 0 wins)
    localparam int SRC_IBUS = 0;
    localparam int SRC_DBUS = 1;
    localparam int SRC_MIS  = 2;
    localparam int SRC_STK  = 3;
    localparam int SRC_DIV  = 4;
    localparam int SRC_FPU  = 5;

    typedef logic [CAUSE_W-1:0] cause_t;

    localparam cause_t C_MIS  = 5'h01;
    localparam cause_t C_IBUS = 5'h03;
    localparam cause_t C_DBUS = 5'h04;
    localparam cause_t C_DIVZ = 5'h05;
    localparam cause_t C_FPU  = 5'h06;
    localparam cause_t C_STK  = 5'h07;

    // Bit positions of the misaligned-access detail fields
    localparam int RD_LSB = 5;
    localparam int WR_BIT = 10;

    // Map a source index to its cause code
    function automatic cause_t cause_of(input int idx);
        case (idx)
            SRC_IBUS: cause_of = C_IBUS;
            SRC_DBUS: cause_of = C_DBUS;
            SRC_MIS:  cause_of = C_MIS;
            SRC_STK:  cause_of = C_STK;
            SRC_DIV:  cause_of = C_DIVZ;
            default:  cause_of = C_FPU;
        endcase
    endfunction
endpackage

// File: rtl/exc_stack_cmp.sv
// Stack window comparator.
// Flags an access whose address lies outside [lo, hi]; both limits are legal.
// Assumes unsigned addresses and lo <= hi as programmed by software.
module exc_stack_cmp #(
    parameter int AW = 32
) (
    input  logic          req,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic          viol
);
    logic below;
    logic above;

    // Strict comparisons against each limit
    always_comb begin
        below = addr < lo;
        above = addr > hi;
        viol  = req && (below || above);
    end
endmodule

// File: rtl/exc_req_qual.sv
// Request qualifier.
// Applies global enable and per-source configuration to raw fault events
// and produces one request bit per source in priority order.
// Assumes all strobes are single-cycle and already aligned to this stage.
module exc_req_qual
    import exc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int FLW  = 4
) (
    input  logic            irq_en,
    input  logic            cfg_ibus_en,
    input  logic            cfg_dbus_en,
    input  logic            cfg_divz_en,
    input  logic            cfg_fpu_en,
    input  logic            ibus_err,
    input  logic            dbus_err,
    input  logic            mis_req,
    input  logic            stk_viol,
    input  logic            div_req,
    input  logic [XLEN-1:0] div_divisor,
    input  logic            fpu_req,
    input  logic [FLW-1:0]  fpu_flags,
    output logic [NSRC-1:0] req
);
    logic div_zero;
    logic fpu_any;

    // Detect the zero divisor and any raised floating-point flag
    always_comb begin
        div_zero = (div_divisor == '0);
        fpu_any  = |fpu_flags;
    end

    // Gate each source by its own enables
    always_comb begin
        req           = '0;
        req[SRC_IBUS] = ibus_err && irq_en && cfg_ibus_en;
        req[SRC_DBUS] = dbus_err && irq_en && cfg_dbus_en;
        req[SRC_MIS]  = mis_req && irq_en;
        req[SRC_STK]  = stk_viol;
        req[SRC_DIV]  = div_req && div_zero && irq_en && cfg_divz_en;
        req[SRC_FPU]  = fpu_req && fpu_any && irq_en && cfg_fpu_en;
    end
endmodule

// File: rtl/exc_prio_enc.sv
// Fixed-priority arbiter: bit 0 is the most urgent.
// Produces a one-hot (or empty) grant vector and an any-request flag.
module exc_prio_enc #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    logic [N-1:0] seen;

    // Prefix-OR of more urgent requests, then mask
    assign seen[0]  = 1'b0;
    assign grant[0] = req[0];
    for (genvar i = 1; i < N; i++) begin : g_chain
        assign seen[i]  = seen[i-1] | req[i-1];
        assign grant[i] = req[i] & ~seen[i];
    end

    assign any = |req;
endmodule

// File: rtl/exc_esr_reg.sv
// Status register and take pulse.
// Builds the status word for the granted source and loads it on take.
// Assumes grant is one-hot or empty.
module exc_esr_reg
    import exc_pkg::*;
#(
    parameter int W    = 32,
    parameter int RIDX = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] grant,
    input  logic            any,
    input  logic            mis_wr,
    input  logic [RIDX-1:0] mis_rd,
    output logic [W-1:0]    esr,
    output logic            exc_take
);
    cause_t       cause_n;
    logic [W-1:0] word_n;

    // OR together the codes of granted sources (one at most)
    always_comb begin
        cause_n = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) cause_n = cause_n | cause_of(i);
        end
    end

    // Assemble the full status word, with access details for misalignment
    always_comb begin
        word_n                  = '0;
        word_n[CAUSE_W-1:0]     = cause_n;
        if (grant[SRC_MIS]) begin
            word_n[WR_BIT]               = mis_wr;
            word_n[RD_LSB +: RIDX]       = mis_rd;
        end
    end

    // Register the word and the pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esr      <= '0;
            exc_take <= 1'b0;
        end else begin
            exc_take <= any;
            if (any) esr <= word_n;
        end
    end
endmodule

// File: rtl/exc_cause_unit.sv
// Exception cause unit top.
// Qualifies fault events, selects one by priority, records it in the
// status register and overrides the quotient of a zero-divisor divide.
// Assumes events are sampled in the cycle their strobe is high.
module exc_cause_unit
    import exc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int AW   = 32,
    parameter int RIDX = 5,
    parameter int FLW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_en,
    input  logic            cfg_ibus_en,
    input  logic            cfg_dbus_en,
    input  logic            cfg_divz_en,
    input  logic            cfg_fpu_en,
    input  logic            ibus_err,
    input  logic            dbus_err,
    input  logic            mis_req,
    input  logic            mis_wr,
    input  logic [RIDX-1:0] mis_rd,
    input  logic            stk_req,
    input  logic [AW-1:0]   stk_addr,
    input  logic [AW-1:0]   stk_lo,
    input  logic [AW-1:0]   stk_hi,
    input  logic            div_req,
    input  logic [XLEN-1:0] div_divisor,
    input  logic [XLEN-1:0] div_quot_in,
    output logic [XLEN-1:0] div_quot_out,
    input  logic            fpu_req,
    input  logic [FLW-1:0]  fpu_flags,
    output logic [XLEN-1:0] esr,
    output logic            exc_take
);
    logic            stk_viol;
    logic [NSRC-1:0] req;
    logic [NSRC-1:0] grant;
    logic            any;

    exc_stack_cmp #(.AW(AW)) u_stk (
        .req  (stk_req),
        .addr (stk_addr),
        .lo   (stk_lo),
        .hi   (stk_hi),
        .viol (stk_viol)
    );

    exc_req_qual #(.XLEN(XLEN), .FLW(FLW)) u_qual (
        .irq_en      (irq_en),
        .cfg_ibus_en (cfg_ibus_en),
        .cfg_dbus_en (cfg_dbus_en),
        .cfg_divz_en (cfg_divz_en),
        .cfg_fpu_en  (cfg_fpu_en),
        .ibus_err    (ibus_err),
        .dbus_err    (dbus_err),
        .mis_req     (mis_req),
        .stk_viol    (stk_viol),
        .div_req     (div_req),
        .div_divisor (div_divisor),
        .fpu_req     (fpu_req),
        .fpu_flags   (fpu_flags),
        .req         (req)
    );

    exc_prio_enc #(.N(NSRC)) u_prio (
        .req   (req),
        .grant (grant),
        .any   (any)
    );

    exc_esr_reg #(.W(XLEN), .RIDX(RIDX)) u_esr (
        .clk      (clk),
        .rst_n    (rst_n),
        .grant    (grant),
        .any      (any),
        .mis_wr   (mis_wr),
        .mis_rd   (mis_rd),
        .esr      (esr),
        .exc_take (exc_take)
    );

    // Zero divisor yields a defined zero quotient
    always_comb begin
        div_quot_out = (div_divisor == '0) ? '0 : div_quot_in;
    end
endmodule

// File: rtl/exc_cause_chk.sv
// Checker for the exception cause unit, bound to every instance.
module exc_cause_chk #(
    parameter int XLEN = 32,
    parameter int AW   = 32,
    parameter int RIDX = 5,
    parameter int FLW  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_en,
    input logic            cfg_ibus_en,
    input logic            cfg_dbus_en,
    input logic            cfg_divz_en,
    input logic            cfg_fpu_en,
    input logic            ibus_err,
    input logic            dbus_err,
    input logic            mis_req,
    input logic            mis_wr,
    input logic [RIDX-1:0] mis_rd,
    input logic            stk_req,
    input logic [AW-1:0]   stk_addr,
    input logic [AW-1:0]   stk_lo,
    input logic [AW-1:0]   stk_hi,
    input logic            div_req,
    input logic [XLEN-1:0] div_divisor,
    input logic [XLEN-1:0] div_quot_out,
    input logic            fpu_req,
    input logic [FLW-1:0]  fpu_flags,
    input logic [XLEN-1:0] esr,
    input logic            exc_take
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (esr == '0 && !exc_take));

    // R2
    divz_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && esr[4:0] == 5'h05) |->
        $past(div_req && div_divisor == '0 && irq_en && cfg_divz_en));

    // R3
    quot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_divisor == '0) |-> (div_quot_out == '0));

    // R4
    mis_detail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && esr[4:0] == 5'h01) |->
        (esr[10] == $past(mis_wr) && esr[9:5] == $past(mis_rd) && $past(irq_en)));

    // R5
    stk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && esr[4:0] == 5'h07) |->
        $past(stk_req && (stk_addr < stk_lo || stk_addr > stk_hi)));

    // R6
    ibus_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && esr[4:0] == 5'h03) |-> $past(ibus_err && irq_en && cfg_ibus_en));

    // R7
    dbus_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && esr[4:0] == 5'h04) |-> $past(dbus_err && irq_en && cfg_dbus_en));

    // R8
    fpu_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && esr[4:0] == 5'h06) |->
        $past(fpu_req && (|fpu_flags) && irq_en && cfg_fpu_en));

    // R9
    prio_dbus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && esr[4:0] == 5'h04) |-> !$past(ibus_err && irq_en && cfg_ibus_en));

    // R10
    esr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_take && $past(rst_n)) |-> $stable(esr));
endmodule

bind exc_cause_unit exc_cause_chk #(
    .XLEN(XLEN), .AW(AW), .RIDX(RIDX), .FLW(FLW)
) u_chk (.*);

// File: tb/sim_exc_cause_unit.sv
`timescale 1ns/1ps
module sim_exc_cause_unit;
    typedef struct packed {
        logic [3:0]  rq;     // requirement number for the message
        logic        ee;
        logic [3:0]  cfg;    // {ibus, dbus, divz, fpu}
        logic        ib;
        logic        db;
        logic        mis;
        logic        mwr;
        logic [4:0]  mrd;
        logic        stk;
        logic [31:0] saddr;
        logic        dv;
        logic [31:0] dsr;
        logic        fp;
        logic [3:0]  fl;
        logic        take;
        logic [31:0] xesr;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        // R2: trapped zero divide, then ungated cases hold the old value
        '{4'd2, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 32'h0,    1'b1, 32'd0, 1'b0, 4'h0, 1'b1, 32'h5},
        '{4'd2, 1'b1, 4'hD, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 32'h0,    1'b1, 32'd0, 1'b0, 4'h0, 1'b0, 32'h5},
        '{4'd2, 1'b0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 32'h0,    1'b1, 32'd0, 1'b0, 4'h0, 1'b0, 32'h5},
        '{4'd2, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 32'h0,    1'b1, 32'd7, 1'b0, 4'h0, 1'b0, 32'h5},
        // R4: misaligned detail fields, gated by global enable
        '{4'd4, 1'b1, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 5'h13, 1'b0, 32'h0,    1'b0, 32'd1, 1'b0, 4'h0, 1'b1, 32'h661},
        '{4'd4, 1'b0, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 5'h07, 1'b0, 32'h0,    1'b0, 32'd1, 1'b0, 4'h0, 1'b0, 32'h661},
        '{4'd4, 1'b1, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 5'h1F, 1'b0, 32'h0,    1'b0, 32'd1, 1'b0, 4'h0, 1'b1, 32'h3E1},
        // R5: window edges, limits 0x1000..0x2000, independent of enable
        '{4'd5, 1'b0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 32'h0FFF, 1'b0, 32'd1, 1'b0, 4'h0, 1'b1, 32'h7},
        '{4'd5, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 32'h1000, 1'b0, 32'd1, 1'b0, 4'h0, 1'b0, 32'h7},
        '{4'd5, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 32'h2000, 1'b0, 32'd1, 1'b0, 4'h0, 1'b0, 32'h7},
        // R6: instruction bus error
        '{4'd6, 1'b1, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 32'h0,    1'b0, 32'd1, 1'b0, 4'h0, 1'b1, 32'h3},
        '{4'd5, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 32'h2001, 1'b0, 32'd1, 1'b0, 4'h0, 1'b1, 32'h7},
        '{4'd6, 1'b1, 4'h7, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 32'h0,    1'b0, 32'd1, 1'b0, 4'h0, 1'b0, 32'h7},
        '{4'd6, 1'b0, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 32'h0,    1'b0, 32'd1, 1'b0, 4'h0, 1'b0, 32'h7},
        // R7: data bus error
        '{4'd7, 1'b1, 4'hF, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0, 32'h0,    1'b0, 32'd1, 1'b0, 4'h0, 1'b1, 32'h4},
        '{4'd7, 1'b1, 4'hB, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0, 32'h0,    1'b0, 32'd1, 1'b0, 4'h0, 1'b0, 32'h4},
        // R8: floating point flags, config and enable
        '{4'd8, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 32'h0,    1'b0, 32'd1, 1'b1, 4'h0, 1'b0, 32'h4},
        '{4'd8, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 32'h0,    1'b0, 32'd1, 1'b1, 4'h2, 1'b1, 32'h6},
        '{4'd8, 1'b1, 4'hE, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 32'h0,    1'b0, 32'd1, 1'b1, 4'h1, 1'b0, 32'h6},
        '{4'd8, 1'b0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 32'h0,    1'b0, 32'd1, 1'b1, 4'h8, 1'b0, 32'h6},
        // R9: peel off the winner one level at a time
        '{4'd9, 1'b1, 4'hF, 1'b1, 1'b1, 1'b1, 1'b1, 5'h02, 1'b1, 32'h0,    1'b1, 32'd0, 1'b1, 4'h1, 1'b1, 32'h3},
        '{4'd9, 1'b1, 4'hF, 1'b0, 1'b1, 1'b1, 1'b1, 5'h02, 1'b1, 32'h0,    1'b1, 32'd0, 1'b1, 4'h1, 1'b1, 32'h4},
        '{4'd9, 1'b1, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 5'h02, 1'b1, 32'h0,    1'b1, 32'd0, 1'b1, 4'h1, 1'b1, 32'h441},
        '{4'd9, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 1'b1, 5'h02, 1'b1, 32'h0,    1'b1, 32'd0, 1'b1, 4'h1, 1'b1, 32'h7},
        '{4'd9, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 1'b1, 5'h02, 1'b0, 32'h0,    1'b1, 32'd0, 1'b1, 4'h1, 1'b1, 32'h5},
        '{4'd9, 1'b1, 4'h7, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0, 32'h0,    1'b0, 32'd1, 1'b0, 4'h0, 1'b1, 32'h4},
        '{4'd8, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 32'h0,    1'b0, 32'd1, 1'b1, 4'h4, 1'b1, 32'h6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_en = 1'b0;
    logic        cfg_ibus_en = 1'b0, cfg_dbus_en = 1'b0, cfg_divz_en = 1'b0, cfg_fpu_en = 1'b0;
    logic        ibus_err = 1'b0, dbus_err = 1'b0, mis_req = 1'b0, mis_wr = 1'b0;
    logic [4:0]  mis_rd = '0;
    logic        stk_req = 1'b0;
    logic [31:0] stk_addr = '0;
    logic [31:0] stk_lo = 32'h1000;
    logic [31:0] stk_hi = 32'h2000;
    logic        div_req = 1'b0;
    logic [31:0] div_divisor = 32'd1;
    logic [31:0] div_quot_in = '0;
    logic [31:0] div_quot_out;
    logic        fpu_req = 1'b0;
    logic [3:0]  fpu_flags = '0;
    logic [31:0] esr;
    logic        exc_take;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    exc_cause_unit u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ibus_err = 0; dbus_err = 0; mis_req = 0; stk_req = 0;
        div_req = 0; fpu_req = 0; div_divisor = 32'd1; fpu_flags = '0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #40000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 esr", esr, 32'h0);
        check("R1 take", {31'd0, exc_take}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            irq_en      = VECS[i].ee;
            cfg_ibus_en = VECS[i].cfg[3];
            cfg_dbus_en = VECS[i].cfg[2];
            cfg_divz_en = VECS[i].cfg[1];
            cfg_fpu_en  = VECS[i].cfg[0];
            ibus_err    = VECS[i].ib;
            dbus_err    = VECS[i].db;
            mis_req     = VECS[i].mis;
            mis_wr      = VECS[i].mwr;
            mis_rd      = VECS[i].mrd;
            stk_req     = VECS[i].stk;
            stk_addr    = VECS[i].saddr;
            div_req     = VECS[i].dv;
            div_divisor = VECS[i].dsr;
            fpu_req     = VECS[i].fp;
            fpu_flags   = VECS[i].fl;
            @(posedge clk);
            #1;
            check($sformatf("R%0d vec%0d take", VECS[i].rq, i), {31'd0, exc_take}, {31'd0, VECS[i].take});
            check($sformatf("R%0d vec%0d esr", VECS[i].rq, i), esr, VECS[i].xesr);
        end

        // R10: pulse drops and value holds once requests stop
        @(negedge clk);
        idle();
        @(posedge clk);
        #1;
        check("R10 take low", {31'd0, exc_take}, 32'h0);
        check("R10 esr hold", esr, 32'h6);

        // R10: back-to-back traps give a take in each following cycle
        @(negedge clk);
        irq_en = 1; cfg_dbus_en = 1; dbus_err = 1;
        @(posedge clk);
        #1;
        check("R10 take first", {31'd0, exc_take}, 32'h1);
        @(negedge clk);
        dbus_err = 0; stk_req = 1; stk_addr = 32'h3000;
        @(posedge clk);
        #1;
        check("R10 take second", {31'd0, exc_take}, 32'h1);
        check("R5 esr second", esr, 32'h7);

        // R3: quotient override is combinational
        @(negedge clk);
        idle();
        div_quot_in = 32'hABCD_1234; div_divisor = 32'd0; cfg_divz_en = 0;
        #1;
        check("R3 zero divisor", div_quot_out, 32'h0);
        div_divisor = 32'd3;
        #1;
        check("R3 pass through", div_quot_out, 32'hABCD_1234);
        div_req = 1; div_divisor = 32'd0;
        @(posedge clk);
        #1;
        check("R2 untrapped no take", {31'd0, exc_take}, 32'h0);
        check("R3 untrapped result", div_quot_out, 32'h0);

        // R1: reset in mid-run clears the register
        @(negedge clk);
        idle();
        rst_n = 0;
        @(posedge clk);
        #1;
        check("R1 mid reset esr", esr, 32'h0);
        check("R1 mid reset take", {31'd0, exc_take}, 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule